// File: doc/BRIEF.md
# Amplifier Channel Register Wrapper

This block is the bus-side register wrapper for a single analog amplifier channel. Software reaches it through four word-wide registers on an APB slave port. Three control bits drive the analog macro: one powers the amplifier, one turns on its Schmitt-trigger digital buffer, and one allows the change interrupt. The macro's comparator-style digital output arrives with no clock relation to the bus. The block synchronises it, shows it to software, and catches every transition in a sticky flag. That flag raises the interrupt line when it is allowed to.

The wrapper also runs the amplifier's offset calibration. Software writes a start bit, and only an amplifier that is already powered accepts it. The block holds the start line high toward the macro until the macro's done line rises. It then records the two pass/fail results (NMOS stage and PMOS stage), sets a done bit and drops the start bit by itself. A reference-mode bit goes straight to the macro. With it software picks a half-supply reference (0) or a high-to-low common-mode sweep (1).

Top module: `afe_chan_ctrl`

## Requirements
- R1: After reset every register reads 0 and `amp_en_o`, `dbuf_en_o`, `cal_start_o`, `cal_ref_o` and `irq_o` are all 0.
- R2: The control register (byte offset 0x0) holds the amplifier enable in bit 0, the buffer enable in bit 4 and the interrupt enable in bit 8. It reads back exactly these bits, drives `amp_en_o` from bit 0 and `dbuf_en_o` from bit 4, and ignores every other bit written.
- R3: Status (offset 0x4) bit 0 shows `dout_async_i` after a two-flop synchroniser, so a change shows by the second rising clock edge after it. The bit reads 0 whenever the buffer enable is 0.
- R4: Status bit 4 is set by the third rising edge after any rise or fall of `dout_async_i` while the buffer enable is 1. Transitions while the buffer is off set nothing, and switching the buffer on over a steady line sets nothing.
- R5: Writing 1 to status bit 4 clears the flag. Writing 0 leaves it unchanged. If a hardware set and a clear write fall in the same cycle, the flag ends up set.
- R6: `irq_o` is high exactly while the flag and the interrupt enable are both 1.
- R7: Calibration control (offset 0x8) bit 16 holds the reference mode, drives `cal_ref_o` and reads back.
- R8: Writing 1 to calibration control bit 0 while the amplifier enable is 1 sets the trigger. `cal_start_o` goes to 1, bit 0 reads 1 and the done bit is cleared. With the amplifier enable at 0 the write does not set the trigger and bit 0 reads 0.
- R9: While the trigger is set, a rising edge of `cal_done_async_i` finishes calibration by the third rising clock edge. Calibration status (offset 0xC) then reads done=1 in bit 0, the `cal_nfail_i` level in bit 1 and the `cal_pfail_i` level in bit 2, and the trigger clears. A done edge with no calibration running changes nothing.
- R10: Calibration status is read-only, and writes to offset 0xC leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address (bits 3:2 pick the register) |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data, 0 when not reading |
| amp_en_o | output | 1 | Amplifier power enable to the macro |
| dbuf_en_o | output | 1 | Schmitt-trigger buffer enable to the macro |
| cal_start_o | output | 1 | Calibration start to the macro |
| cal_ref_o | output | 1 | Calibration reference mode to the macro |
| dout_async_i | input | 1 | Buffer digital output from the macro, asynchronous |
| cal_done_async_i | input | 1 | Calibration done from the macro, asynchronous |
| cal_nfail_i | input | 1 | NMOS calibration result, 1 = fail, stable around done |
| cal_pfail_i | input | 1 | PMOS calibration result, 1 = fail, stable around done |
| irq_o | output | 1 | Interrupt request |

## Verification
Register writes take effect at the access-phase edge. The control outputs and read-back can be sampled at the next falling edge. A digital-output change is due in status bit 0 two rising edges later and in the flag three edges later. A calibration done edge is due in the status three edges later. The bench changes each asynchronous input just after a falling edge and counts rising edges before each read. It also samples one edge early to confirm that a result has not yet arrived. The set-versus-clear collision is arranged by starting the clear write one edge after the line change, so that its access edge matches the flag's set edge.

// File: rtl/afe_chan_pkg.sv
// Shared field positions and types for the amplifier channel wrapper.
package afe_chan_pkg;

    // Control register fields
    localparam int CTRL_AMP_BIT  = 0;
    localparam int CTRL_BUF_BIT  = 4;
    localparam int CTRL_IE_BIT   = 8;
    // Status register fields
    localparam int ST_DOUT_BIT   = 0;
    localparam int ST_FLAG_BIT   = 4;
    // Calibration control fields
    localparam int CAL_TRIG_BIT  = 0;
    localparam int CAL_REF_BIT   = 16;
    // Calibration status fields
    localparam int CS_DONE_BIT   = 0;
    localparam int CS_NFAIL_BIT  = 1;
    localparam int CS_PFAIL_BIT  = 2;

    // Word index taken from byte address bits [3:2]
    localparam int REG_IDX_LSB   = 2;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_CALC = 2'd2,
        REG_CALS = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic done;
        logic nfail;
        logic pfail;
    } cal_res_t;

endpackage

// File: rtl/afe_sync.sv
// Multi-flop synchroniser for asynchronous level inputs.
// Assumes each input bit is a level that is stable for several clocks;
// bits are synchronised independently (no cross-bit coherence).
module afe_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] pipe [STAGES];

    // First stage captures the raw asynchronous level
    always_ff @(posedge clk) begin
        if (!rst_n) pipe[0] <= '0;
        else        pipe[0] <= d;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            // Each further stage resolves metastability of the one before
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[s] <= '0;
                else        pipe[s] <= pipe[s-1];
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/afe_dout_flag.sv
// Digital-output visibility and sticky change flag.
// Takes the already synchronised output level. Any transition seen while the
// buffer is enabled sets the flag one clock after it appears on dout_s.
// A clear request in the same cycle as a set loses to the set.
module afe_dout_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic dout_s,
    input  logic buf_en,
    input  logic clr_req,
    output logic flag_q,
    output logic dout_vis
);

    logic prev_q;
    logic set_evt;

    assign set_evt  = buf_en & (dout_s ^ prev_q);
    assign dout_vis = dout_s & buf_en;

    // Track the previous synchronised level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= dout_s;
    end

    // Sticky flag: hardware set has priority over software clear
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= set_evt | (flag_q & ~clr_req);
    end

endmodule

// File: rtl/afe_cal_seq.sv
// Calibration handshake sequencer.
// A start request is accepted only when the amplifier is enabled and no
// calibration is running; it raises the trigger and clears done. A rising
// edge of the synchronised done line while triggered latches the results
// and drops the trigger. Result inputs are assumed stable around done.
module afe_cal_seq
    import afe_chan_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start_req,
    input  logic     amp_en,
    input  logic     done_s,
    input  logic     nfail_i,
    input  logic     pfail_i,
    output logic     trig_q,
    output cal_res_t res_q
);

    logic done_prev_q;
    logic done_rise;
    logic accept;

    assign done_rise = done_s & ~done_prev_q;
    assign accept    = start_req & amp_en & ~trig_q;

    // Remember previous done level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) done_prev_q <= 1'b0;
        else        done_prev_q <= done_s;
    end

    // Trigger and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q <= 1'b0;
            res_q  <= '0;
        end else if (accept) begin
            trig_q     <= 1'b1;
            res_q.done <= 1'b0;
        end else if (trig_q && done_rise) begin
            trig_q      <= 1'b0;
            res_q.done  <= 1'b1;
            res_q.nfail <= nfail_i;
            res_q.pfail <= pfail_i;
        end
    end

endmodule

// File: rtl/afe_chan_ctrl.sv
// Amplifier channel register wrapper, top level.
// APB slave with four word registers (control, status, calibration control,
// calibration status). Writes commit on the access phase; reads are returned
// combinationally with no wait states. Assumes DATA_W >= 17 and ADDR_W >= 4.
module afe_chan_ctrl
    import afe_chan_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              amp_en_o,
    output logic              dbuf_en_o,
    output logic              cal_start_o,
    output logic              cal_ref_o,
    input  logic              dout_async_i,
    input  logic              cal_done_async_i,
    input  logic              cal_nfail_i,
    input  logic              cal_pfail_i,
    output logic              irq_o
);

    localparam int NUM_ASYNC = 2;

    reg_sel_e sel;
    logic     wr_en;
    logic     rd_en;
    logic     amp_en_q, buf_en_q, ie_q, ref_q;
    logic     st_clr;
    logic     cal_start_req;
    logic     flag_q;
    logic     dout_vis;
    logic     trig_q;
    cal_res_t cal_res_q;
    logic [NUM_ASYNC-1:0] async_raw, async_s;
    logic     unused_bits;

    assign sel   = reg_sel_e'(paddr[REG_IDX_LSB +: 2]);
    assign wr_en = psel & penable & pwrite;
    assign rd_en = psel & ~pwrite;

    assign st_clr        = wr_en && (sel == REG_STAT) && pwdata[ST_FLAG_BIT];
    assign cal_start_req = wr_en && (sel == REG_CALC) && pwdata[CAL_TRIG_BIT];

    assign unused_bits = ^{paddr, pwdata};

    // Control register: enables toward the macro and interrupt enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            amp_en_q <= 1'b0;
            buf_en_q <= 1'b0;
            ie_q     <= 1'b0;
        end else if (wr_en && sel == REG_CTRL) begin
            amp_en_q <= pwdata[CTRL_AMP_BIT];
            buf_en_q <= pwdata[CTRL_BUF_BIT];
            ie_q     <= pwdata[CTRL_IE_BIT];
        end
    end

    // Calibration reference mode, written with calibration control
    always_ff @(posedge clk) begin
        if (!rst_n)                        ref_q <= 1'b0;
        else if (wr_en && sel == REG_CALC) ref_q <= pwdata[CAL_REF_BIT];
    end

    assign async_raw = {cal_done_async_i, dout_async_i};

    afe_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (NUM_ASYNC)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (async_raw),
        .q     (async_s)
    );

    afe_dout_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .dout_s   (async_s[0]),
        .buf_en   (buf_en_q),
        .clr_req  (st_clr),
        .flag_q   (flag_q),
        .dout_vis (dout_vis)
    );

    afe_cal_seq u_cal (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (cal_start_req),
        .amp_en    (amp_en_q),
        .done_s    (async_s[1]),
        .nfail_i   (cal_nfail_i),
        .pfail_i   (cal_pfail_i),
        .trig_q    (trig_q),
        .res_q     (cal_res_q)
    );

    // Read data multiplexer, zero outside read cycles
    always_comb begin
        prdata = '0;
        if (rd_en) begin
            unique case (sel)
                REG_CTRL: begin
                    prdata[CTRL_AMP_BIT] = amp_en_q;
                    prdata[CTRL_BUF_BIT] = buf_en_q;
                    prdata[CTRL_IE_BIT]  = ie_q;
                end
                REG_STAT: begin
                    prdata[ST_DOUT_BIT] = dout_vis;
                    prdata[ST_FLAG_BIT] = flag_q;
                end
                REG_CALC: begin
                    prdata[CAL_TRIG_BIT] = trig_q;
                    prdata[CAL_REF_BIT]  = ref_q;
                end
                REG_CALS: begin
                    prdata[CS_DONE_BIT]  = cal_res_q.done;
                    prdata[CS_NFAIL_BIT] = cal_res_q.nfail;
                    prdata[CS_PFAIL_BIT] = cal_res_q.pfail;
                end
                default: prdata = '0;
            endcase
        end
    end

    assign amp_en_o    = amp_en_q;
    assign dbuf_en_o   = buf_en_q;
    assign cal_start_o = trig_q;
    assign cal_ref_o   = ref_q;
    assign irq_o       = flag_q & ie_q;

endmodule

// File: rtl/afe_chan_ctrl_chk.sv
// Property checker for afe_chan_ctrl, attached through bind.
// Observes top-level ports and the state handed between submodules.
module afe_chan_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic amp_en_o,
    input logic dbuf_en_o,
    input logic cal_start_o,
    input logic flag_q,
    input logic st_clr,
    input logic cal_done,
    input logic cal_nfail,
    input logic cal_pfail
);

    // R4: the flag only rises if the buffer was enabled when it was set
    p_flag_needs_buf_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(dbuf_en_o));

    // R5: the flag only falls after a clear write
    p_flag_fall_on_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q) |-> $past(st_clr));

    // R8: the trigger only starts with the amplifier already enabled
    p_start_needs_amp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_start_o) |-> $past(amp_en_o));

    // R8: a new calibration starts with done cleared
    p_start_clears_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_start_o) |-> !cal_done);

    // R9: the trigger only drops once done is reported
    p_stop_sets_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cal_start_o) |-> cal_done);

    // R9: results do not move while no calibration was running
    p_results_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cal_start_o) |-> ($stable(cal_nfail) && $stable(cal_pfail)));

endmodule

bind afe_chan_ctrl afe_chan_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .amp_en_o    (amp_en_o),
    .dbuf_en_o   (dbuf_en_o),
    .cal_start_o (cal_start_o),
    .flag_q      (flag_q),
    .st_clr      (st_clr),
    .cal_done    (cal_res_q.done),
    .cal_nfail   (cal_res_q.nfail),
    .cal_pfail   (cal_res_q.pfail)
);

// File: tb/afe_chan_ctrl_test.sv
// Self-checking bench for afe_chan_ctrl: a register vector table first,
// then directed sequences for synchronisation timing, flag and calibration.
module afe_chan_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [3:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        amp_en_o, dbuf_en_o, cal_start_o, cal_ref_o, irq_o;
    logic        dout_async_i = 1'b0, cal_done_async_i = 1'b0;
    logic        cal_nfail_i = 1'b0, cal_pfail_i = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    localparam logic [3:0] A_CTRL = 4'h0, A_STAT = 4'h4, A_CALC = 4'h8, A_CALS = 4'hC;

    always #10 clk = ~clk;  // 50 MHz

    afe_chan_ctrl uut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .amp_en_o(amp_en_o), .dbuf_en_o(dbuf_en_o), .cal_start_o(cal_start_o),
        .cal_ref_o(cal_ref_o), .dout_async_i(dout_async_i),
        .cal_done_async_i(cal_done_async_i), .cal_nfail_i(cal_nfail_i),
        .cal_pfail_i(cal_pfail_i), .irq_o(irq_o)
    );

    typedef struct packed {
        logic        wr;
        logic [3:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 4'h0, 32'h0000_0111, 32'h0, 8'd2},
        '{1'b0, 4'h0, 32'h0,         32'h0000_0111, 8'd2},  // R2 all enables
        '{1'b1, 4'h0, 32'hFFFF_FEEE, 32'h0, 8'd2},
        '{1'b0, 4'h0, 32'h0,         32'h0000_0000, 8'd2},  // R2 other bits ignored
        '{1'b1, 4'h0, 32'h0000_0010, 32'h0, 8'd2},
        '{1'b0, 4'h0, 32'h0,         32'h0000_0010, 8'd2},  // R2 buffer only
        '{1'b1, 4'h8, 32'h0001_0000, 32'h0, 8'd7},
        '{1'b0, 4'h8, 32'h0,         32'h0001_0000, 8'd7},  // R7 sweep mode
        '{1'b1, 4'h8, 32'h0000_0000, 32'h0, 8'd7},
        '{1'b0, 4'h8, 32'h0,         32'h0000_0000, 8'd7},  // R7 half-supply mode
        '{1'b0, 4'hC, 32'h0,         32'h0000_0000, 8'd10}  // R10 idle status
    };

    // Compare and count one check
    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Write: starts and ends just after a falling edge; commits on the 2nd rising edge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    // Read: no clock edge passes
    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
        #2;
        d = prdata;
        psel = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] v;
        rd(a, v);
        chk(v, exp, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1: reset state
        rd_chk(A_CTRL, 32'h0, "R1 ctrl");
        rd_chk(A_STAT, 32'h0, "R1 status");
        rd_chk(A_CALC, 32'h0, "R1 calctl");
        rd_chk(A_CALS, 32'h0, "R1 calst");
        chk({27'd0, amp_en_o, dbuf_en_o, cal_start_o, cal_ref_o, irq_o}, 32'h0, "R1 outputs");

        // Vector table walk
        for (int i = 0; i < NVEC; i++) begin
            if (VECS[i].wr) wr(VECS[i].addr, VECS[i].data);
            else rd_chk(VECS[i].addr, VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i));
        end

        // R2: enables reach the ports
        wr(A_CTRL, 32'h111);
        chk({30'd0, amp_en_o, dbuf_en_o}, 32'h3, "R2 port enables");

        // R3/R4/R6: rising output, sample one edge early each time
        dout_async_i = 1'b1;
        tick(1);
        rd_chk(A_STAT, 32'h00, "R3 not yet after one edge");
        tick(1);
        rd_chk(A_STAT, 32'h01, "R3 visible after two edges");
        chk({31'd0, irq_o}, 32'h0, "R6 no irq before flag");
        tick(1);
        rd_chk(A_STAT, 32'h11, "R4 flag after rise");
        chk({31'd0, irq_o}, 32'h1, "R6 irq with flag and enable");

        // R5: clear
        wr(A_STAT, 32'h10);
        rd_chk(A_STAT, 32'h01, "R5 clear by writing one");
        chk({31'd0, irq_o}, 32'h0, "R6 irq drops with flag");

        // R4: falling output
        dout_async_i = 1'b0;
        tick(3);
        rd_chk(A_STAT, 32'h10, "R4 flag after fall");
        wr(A_STAT, 32'h00);
        rd_chk(A_STAT, 32'h10, "R5 writing zero keeps flag");
        wr(A_CTRL, 32'h011);
        chk({31'd0, irq_o}, 32'h0, "R6 irq masked by enable");
        wr(A_STAT, 32'h10);
        rd_chk(A_STAT, 32'h00, "R5 flag cleared");

        // R5: set and clear in the same cycle, set wins
        dout_async_i = 1'b1;
        tick(1);
        wr(A_STAT, 32'h10);
        rd_chk(A_STAT, 32'h11, "R5 set beats clear");
        wr(A_STAT, 32'h10);
        rd_chk(A_STAT, 32'h01, "R5 later clear");

        // R3/R4: buffer disabled
        wr(A_CTRL, 32'h001);
        chk({31'd0, dbuf_en_o}, 32'h0, "R2 buffer port off");
        rd_chk(A_STAT, 32'h00, "R3 output hidden with buffer off");
        dout_async_i = 1'b0;
        tick(4);
        dout_async_i = 1'b1;
        tick(4);
        rd_chk(A_STAT, 32'h00, "R4 no flag with buffer off");
        wr(A_CTRL, 32'h011);
        tick(2);
        rd_chk(A_STAT, 32'h01, "R4 no flag on buffer enable");

        // R8: start ignored with amplifier off
        wr(A_CTRL, 32'h000);
        wr(A_CALC, 32'h1);
        rd_chk(A_CALC, 32'h0, "R8 start ignored without enable");
        chk({31'd0, cal_start_o}, 32'h0, "R8 start port stays low");

        // R9: done edge with nothing running
        cal_done_async_i = 1'b1;
        tick(4);
        rd_chk(A_CALS, 32'h0, "R9 stray done ignored");
        cal_done_async_i = 1'b0;
        tick(3);

        // R8/R9: first calibration, NMOS fail
        wr(A_CTRL, 32'h001);
        cal_nfail_i = 1'b1; cal_pfail_i = 1'b0;
        wr(A_CALC, 32'h0001_0001);
        rd_chk(A_CALC, 32'h0001_0001, "R8 trigger reads one");
        chk({30'd0, cal_start_o, cal_ref_o}, 32'h3, "R7 R8 start and reference ports");
        rd_chk(A_CALS, 32'h0, "R8 calibrating");
        cal_done_async_i = 1'b1;
        tick(2);
        chk({31'd0, cal_start_o}, 32'h1, "R9 trigger held before done arrives");
        tick(1);
        rd_chk(A_CALS, 32'h3, "R9 done with NMOS fail");
        rd_chk(A_CALC, 32'h0001_0000, "R9 trigger self-cleared");

        // R8/R9: second calibration, PMOS fail
        cal_done_async_i = 1'b0;
        tick(3);
        cal_nfail_i = 1'b0; cal_pfail_i = 1'b1;
        wr(A_CALC, 32'h1);
        chk({31'd0, cal_ref_o}, 32'h0, "R7 half-supply port");
        rd_chk(A_CALS, 32'h2, "R8 done cleared on start");
        cal_done_async_i = 1'b1;
        tick(3);
        rd_chk(A_CALS, 32'h5, "R9 done with PMOS fail");

        // R10: status is read-only
        wr(A_CALS, 32'h0);
        rd_chk(A_CALS, 32'h5, "R10 write ignored");

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule